// File: doc/BRIEF.md
# Nonzero Index Compaction Unit

This block accepts a row of `ROW_LEN` fixed-width elements on a valid/ready input stream and answers with a row of `OUT_LEN` signed 32-bit words on a valid/ready output stream. The output row has three regions. The front holds the positions of the nonzero input elements, in ascending order, each with a runtime index offset added. The middle is filled with a runtime padding word. The final word holds the total number of nonzero elements. A typical use is sparse routing, where the consumer reads a dense list of active positions followed by a known terminator and a population count.

A two-state controller sequences the block. In state COLLECT the unit takes one element per cycle and records the positions of nonzero elements into a small slot store. The transition ROW_DONE fires when the last element of the row is accepted, and the unit enters EMIT. In EMIT it presents one output word per handshake. The transition ROW_SENT fires when the count word is accepted, and the unit returns to COLLECT. The offset, the padding word and the float/integer mode are captured when the first element of a row is accepted. If a row has more nonzero elements than there are index slots, the extra positions are dropped, the count stays exact, and an overflow flag is raised for the whole output row.

Top module: `nzc_compactor`

## Requirements
- R1: Output slots 0 through n-1, where n = min(count, OUT_LEN-1), carry the 0-based row positions of the nonzero elements in ascending order of position.
- R2: Each emitted index equals the element position plus `cfg_index_offset`, using 32-bit two's-complement wraparound.
- R3: The slots from n up to OUT_LEN-2 carry `cfg_pad_value`.
- R4: Slot OUT_LEN-1 carries the exact nonzero count as an unsigned value. `out_last` is high only on this slot. After the slot is accepted, the unit returns to COLLECT.
- R5: An element is nonzero when any of its bits is 1, with one exception: when `cfg_float_mode`=1, the value with only the most significant bit set (negative zero) counts as zero. With `cfg_float_mode`=0, that same value counts as nonzero.
- R6: When the count exceeds OUT_LEN-1, positions beyond the first OUT_LEN-1 are dropped, slot OUT_LEN-1 still reports the true count, and `out_overflow` is 1 on every slot of that row. It is 0 on every slot of other rows.
- R7: In COLLECT, `in_ready`=1 and `out_valid`=0, and one element is accepted per cycle. After the last element is accepted, the next cycle has `in_ready`=0 and `out_valid`=1.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_last` and `out_overflow` hold their values.
- R9: After reset, `in_ready`=1 and `out_valid`=0.
- R10: Offset, padding word and float mode are sampled when element 0 of a row is accepted. Changing them later in that row has no effect on that row's output.
- R11: A row with no nonzero elements produces OUT_LEN-1 padding words followed by a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_index_offset | input | 32 | Signed offset added to every emitted position |
| cfg_pad_value | input | 32 | Word placed in unused index slots |
| cfg_float_mode | input | 1 | 1 treats negative zero as zero |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit accepts an element |
| in_data | input | DATA_W | Input element |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the count slot |
| out_overflow | output | 1 | Row had more nonzeros than index slots |

## Verification
The bench sweeps every nonzero pattern of a default row in both modes. This exposes a unit that reorders positions, forgets the offset, or pads the wrong region. It also catches a count that saturates at the slot limit instead of reporting the true total, or a store that overwrites the last index slot on overflow. Negative-zero elements are placed in both modes. A unit that ignores the mode would either drop or keep them in the wrong mode. The configuration is scrambled mid-row and the output is stalled mid-row. These steps catch a unit that reads live configuration or lets its output drift under backpressure.

// File: rtl/nzc_pkg.sv
package nzc_pkg;
    typedef enum logic [0:0] {
        S_COLLECT = 1'b0,
        S_EMIT    = 1'b1
    } nzc_state_e;
endpackage

// File: rtl/nzc_zero_detect.sv
module nzc_zero_detect #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] elem,
    input  logic              float_mode,
    output logic              is_nonzero
);
    localparam logic [DATA_W-1:0] NEG_ZERO = {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        is_nonzero = |elem;
        if (float_mode && (elem == NEG_ZERO)) begin
            is_nonzero = 1'b0;
        end
    end
endmodule

// File: rtl/nzc_slot_store.sv
module nzc_slot_store #(
    parameter int SLOTS  = 5,
    parameter int POS_W  = 3,
    parameter int ADDR_W = 4,
    parameter int RD_W   = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [RD_W-1:0]   rd_addr,
    output logic [POS_W-1:0]  rd_pos
);
    logic [POS_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (32'(wr_addr) == g)) begin
                slot_q[g] <= wr_pos;
            end
        end
    end

    always_comb begin
        rd_pos = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (32'(rd_addr) == k) begin
                rd_pos = slot_q[k];
            end
        end
    end
endmodule

// File: rtl/nzc_ctrl.sv
module nzc_ctrl
    import nzc_pkg::*;
#(
    parameter int ROW_LEN = 8,
    parameter int OUT_LEN = 6,
    parameter int POS_W   = 3,
    parameter int CNT_W   = 4,
    parameter int SLOT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              elem_nz,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic              first_elem,
    output logic              wr_en,
    output logic [POS_W-1:0]  pos,
    output logic [CNT_W-1:0]  cnt,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(ROW_LEN - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OUT_LEN - 1);

    nzc_state_e state_q, state_d;
    logic       accept;
    logic       row_done;
    logic       row_sent;

    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_last   = 1'b0;
        unique case (state_q)
            S_COLLECT: in_ready = 1'b1;
            S_EMIT: begin
                out_valid = 1'b1;
                out_last  = (slot == LAST_SLOT);
            end
            default: ;
        endcase
    end

    assign accept     = in_valid && in_ready;
    assign first_elem = accept && (pos == '0);
    assign wr_en      = accept && elem_nz;
    assign row_done   = accept && (pos == LAST_POS);
    assign row_sent   = out_valid && out_ready && out_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: if (row_done) state_d = S_EMIT;
            S_EMIT:    if (row_sent) state_d = S_COLLECT;
            default:   state_d = S_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
            pos     <= '0;
            cnt     <= '0;
            slot    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pos <= row_done ? '0 : pos + 1'b1;
                if (elem_nz) begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (out_valid && out_ready) begin
                if (out_last) begin
                    slot <= '0;
                    cnt  <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> (out_valid && !in_ready));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= ROW_LEN);

    assert_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        row_sent |=> (in_ready && (slot == '0)));
endmodule

// File: rtl/nzc_compactor.sv
module nzc_compactor #(
    parameter int DATA_W  = 16,
    parameter int ROW_LEN = 8,
    parameter int OUT_LEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_index_offset,
    input  logic [31:0]       cfg_pad_value,
    input  logic              cfg_float_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_last,
    output logic              out_overflow
);
    localparam int IDX_SLOTS = OUT_LEN - 1;
    localparam int POS_W     = (ROW_LEN > 2) ? $clog2(ROW_LEN) : 1;
    localparam int CNT_W     = $clog2(ROW_LEN + 1);
    localparam int SLOT_W    = (OUT_LEN > 2) ? $clog2(OUT_LEN) : 1;

    logic [31:0]       offset_q;
    logic [31:0]       pad_q;
    logic              float_q;
    logic              mode_now;
    logic              elem_nz;
    logic              first_elem;
    logic              wr_en;
    logic [POS_W-1:0]  pos;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot;
    logic [POS_W-1:0]  rd_pos;
    logic [31:0]       offset_use;
    logic [31:0]       pad_use;

    assign mode_now = (pos == '0) ? cfg_float_mode : float_q;

    nzc_zero_detect #(.DATA_W(DATA_W)) u_detect (
        .elem       (in_data),
        .float_mode (mode_now),
        .is_nonzero (elem_nz)
    );

    nzc_ctrl #(
        .ROW_LEN (ROW_LEN),
        .OUT_LEN (OUT_LEN),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W),
        .SLOT_W  (SLOT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .elem_nz    (elem_nz),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .first_elem (first_elem),
        .wr_en      (wr_en),
        .pos        (pos),
        .cnt        (cnt),
        .slot       (slot)
    );

    nzc_slot_store #(
        .SLOTS  (IDX_SLOTS),
        .POS_W  (POS_W),
        .ADDR_W (CNT_W),
        .RD_W   (SLOT_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en && (32'(cnt) < IDX_SLOTS)),
        .wr_addr (cnt),
        .wr_pos  (pos),
        .rd_addr (slot),
        .rd_pos  (rd_pos)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
            pad_q    <= '0;
            float_q  <= 1'b0;
        end else if (first_elem) begin
            offset_q <= cfg_index_offset;
            pad_q    <= cfg_pad_value;
            float_q  <= cfg_float_mode;
        end
    end

    assign offset_use = offset_q;
    assign pad_use    = pad_q;

    always_comb begin
        out_data = pad_use;
        if (32'(slot) == IDX_SLOTS) begin
            out_data = 32'(cnt);
        end else if (32'(slot) < 32'(cnt)) begin
            out_data = 32'(rd_pos) + offset_use;
        end
    end

    assign out_overflow = out_valid && (32'(cnt) > IDX_SLOTS);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_overflow)));

    assert_overflow_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_valid);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid) |=> $stable(offset_q) && $stable(pad_q));

    initial begin
        assert_len_R6: assert (OUT_LEN >= 2 && ROW_LEN >= 2);
    end
endmodule

// File: tb/nzc_compactor_bench.sv
module nzc_compactor_bench;
    localparam int DATA_W  = 16;
    localparam int ROW_LEN = 8;
    localparam int OUT_LEN = 6;
    localparam int IDX_SLOTS = OUT_LEN - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_index_offset = '0;
    logic [31:0]       cfg_pad_value = '0;
    logic              cfg_float_mode = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_data;
    logic              out_last;
    logic              out_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    nzc_compactor #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN), .OUT_LEN(OUT_LEN)) u_nzc_compactor (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_index_offset (cfg_index_offset),
        .cfg_pad_value    (cfg_pad_value),
        .cfg_float_mode   (cfg_float_mode),
        .in_valid         (in_valid),
        .in_ready         (in_ready),
        .in_data          (in_data),
        .out_valid        (out_valid),
        .out_ready        (out_ready),
        .out_data         (out_data),
        .out_last         (out_last),
        .out_overflow     (out_overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_row(input int row, input logic fmode, input logic [7:0] pat);
        logic [31:0] off;
        logic [31:0] pad;
        int          exp_pos [ROW_LEN];
        int          cnt;
        logic [DATA_W-1:0] v;
        logic [31:0] exp;
        logic [31:0] held;
        off = 32'(row * 37) - 32'd100;
        pad = row[0] ? 32'hFFFF_FFFF : 32'h0000_5A5A;
        cnt = 0;
        for (int i = 0; i < ROW_LEN; i++) begin
            if (pat[i]) v = (i == 3 && !fmode) ? 16'h8000 : 16'((row * 131 + i * 17) | 1);
            else        v = (fmode && i[0]) ? 16'h8000 : 16'h0000;
            // R5: expected nonzero computed from value and mode
            if (v != 0 && !(fmode && v == 16'h8000)) begin
                exp_pos[cnt] = i;
                cnt++;
            end
            @(negedge clk);
            check("R7 in_ready while collecting", 32'(in_ready), 32'd1);
            if (i == 0) begin
                cfg_index_offset = off;
                cfg_pad_value    = pad;
                cfg_float_mode   = fmode;
            end else begin
                // R10: scramble configuration after element 0 accepted
                cfg_index_offset = 32'hDEAD_0000 + 32'(i);
                cfg_pad_value    = 32'h1234_0000 + 32'(i);
                cfg_float_mode   = ~fmode;
            end
            in_valid = 1'b1;
            in_data  = v;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 out_valid after row", 32'(out_valid), 32'd1);
        check("R7 in_ready low in emit", 32'(in_ready), 32'd0);
        for (int k = 0; k < OUT_LEN; k++) begin
            if (k == OUT_LEN - 1)        exp = 32'(cnt);
            else if (k < cnt)            exp = 32'(exp_pos[k]) + off;
            else                         exp = pad;
            if (k == OUT_LEN - 1)        check("R4 count slot", out_data, exp);
            else if (cnt == 0)           check("R11 all-zero pad", out_data, exp);
            else if (k < cnt)            check("R1 R2 index slot", out_data, exp);
            else                         check("R3 pad slot", out_data, exp);
            check("R4 out_last", 32'(out_last), 32'(k == OUT_LEN - 1));
            check("R6 overflow flag", 32'(out_overflow), 32'(cnt > IDX_SLOTS));
            if (((row + k) % 3) == 0) begin
                held = out_data;
                @(negedge clk);
                check("R8 stall hold valid", 32'(out_valid), 32'd1);
                check("R8 stall hold data", out_data, held);
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        check("R4 back to collect", 32'(in_ready), 32'd1);
        check("R4 out_valid low", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset in_ready", 32'(in_ready), 32'd1);
        check("R9 reset out_valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 256; p++) begin
                run_row(m * 256 + p, logic'(m), 8'(p));
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule